// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block models, cycle by cycle, the control timing around a successive-approximation converter. It holds off a new conversion until an acquisition window has elapsed. It then starts one on the convert-start request and keeps a busy flag high for a fixed number of clocks. At the end of that count it captures a digital sample word into the result register. The analog front end is not modelled: the sample word stands in for the comparator path. The captured word is the one that was converted, so there is no pipeline delay, and it is ready on the clock in which busy drops.

Convert-start is active low, and its effect depends on its level when acquisition ends. If it is already low, the conversion begins at once. If it is high, the sequencer arms and waits for the next falling edge. An abort input cancels a running conversion. A power-down input stops new conversions from starting, but lets the current one finish. The acquisition length and the conversion length are parameters counted in clocks. All inputs are synchronous to the one clock.

Top module: `sar_conv_sequencer`

## Requirements
- R1: Each conversion that is not aborted holds `busy` high for exactly `CONV_CYC` consecutive clock cycles.
- R2: `result` changes only on the clock edge at which `busy` falls at the end of a completed conversion. It then holds the word that was on `sample_in` during the final busy cycle.
- R3: Format is chosen by `twos_sel`, sampled together with the data. When `twos_sel` is 0, all bits pass unchanged. When it is 1, only bit `DATA_W-1` (the MSB) is inverted; for example, sample 16'h1234 gives 16'h9234.
- R4: After reset, after a completed conversion and after an abort, `busy` stays low for at least `ACQ_CYC` clock edges before it can rise.
- R5: If `cnv_n` is low on the final acquisition cycle and `pwr_dn` is low, `busy` rises on the next clock edge.
- R6: If `cnv_n` is high on the final acquisition cycle, the sequencer waits. `busy` rises on the edge after the first cycle in which `cnv_n` is sampled low while it was high in the cycle before.
- R7: A low pulse on `cnv_n` that starts and ends within a conversion, or within the acquisition count, starts no conversion.
- R8: `abort` high at a clock edge makes `busy` low after that edge and restarts acquisition. `result` keeps its previous value.
- R9: While `pwr_dn` is high, no conversion starts. A conversion already running completes normally and loads `result`.
- R10: While `rst_n` is low at a clock edge, the block returns to acquisition with `busy` at 0 and `result` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| abort | input | 1 | Cancels a conversion in progress, active high |
| pwr_dn | input | 1 | Blocks new conversions, active high |
| cnv_n | input | 1 | Convert-start request, active low |
| twos_sel | input | 1 | 1 selects twos-complement output (inverted MSB) |
| sample_in | input | DATA_W | Digital stand-in for the comparator result |
| busy | output | 1 | High while a conversion runs; its fall marks new data |
| result | output | DATA_W | Last completed conversion result |

## Verification
The assertions take for granted that every input is synchronous to `clk`. They also assume that `abort` is the only cause of an early fall of `busy`, so the width and data properties exclude any cycle that follows an abort. The stimulus changes inputs only on the falling clock edge. It raises `abort` and `pwr_dn` rarely enough that most conversions complete, so the width and capture checks have plenty of cases to act on.

// File: rtl/sar_conv_pkg.sv
// Package: shared types of the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_conv_pkg;
    typedef enum logic [1:0] {
        PH_ACQ   = 2'd0,   // acquisition count running or expired
        PH_ARMED = 2'd1,   // acquisition done, waiting for a start edge
        PH_CONV  = 2'd2    // conversion count running, busy high
    } seq_phase_t;
endpackage

// File: rtl/cnv_fall_detect.sv
// Module: detects a high-to-low transition of the convert-start request.
// Assumes: cnv_n is synchronous to clk; the history register resets high,
// so a request held low through reset does not count as an edge.
module cnv_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n,
    output logic cnv_fall
);
    logic cnv_q;

    // Keep last cycle's level of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) cnv_q <= 1'b1;
        else        cnv_q <= cnv_n;
    end

    // Edge is present when the level was high and is now low.
    assign cnv_fall = cnv_q & ~cnv_n;
endmodule

// File: rtl/conv_phase_ctrl.sv
// Module: phase controller that sequences acquisition and conversion.
// Assumes: ACQ_CYC >= 1 and CONV_CYC >= 1; abort has priority over every
// phase; pwr_dn only gates the start decision, never a running conversion.
module conv_phase_ctrl
    import sar_conv_pkg::*;
#(
    parameter int ACQ_CYC  = 4,
    parameter int CONV_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic pwr_dn,
    input  logic cnv_n,
    input  logic cnv_fall,
    output logic busy,
    output logic load
);
    localparam int MAX_CYC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ACQ_LD  = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);

    seq_phase_t       phase;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Advance the phase and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase <= PH_ACQ;
            cnt   <= ACQ_LD;
        end else begin
            unique case (phase)
                PH_ACQ: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (!pwr_dn) begin
                        if (!cnv_n) begin
                            phase <= PH_CONV;
                            cnt   <= CONV_LD;
                        end else begin
                            phase <= PH_ARMED;
                        end
                    end
                end
                PH_ARMED: begin
                    if (!pwr_dn && cnv_fall) begin
                        phase <= PH_CONV;
                        cnt   <= CONV_LD;
                    end
                end
                PH_CONV: begin
                    if (cnt_zero) begin
                        phase <= PH_ACQ;
                        cnt   <= ACQ_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_ACQ;
                    cnt   <= ACQ_LD;
                end
            endcase
        end
    end

    // Busy follows the conversion phase; load fires on its last cycle.
    assign busy = (phase == PH_CONV);
    assign load = busy && cnt_zero && !abort;
endmodule

// File: rtl/conv_result_reg.sv
// Module: output register that captures and formats the converted word.
// Assumes: load is a single-cycle strobe; twos_sel is sampled with the data.
module conv_result_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              twos_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] result
);
    localparam int MSB = DATA_W - 1;

    // Capture the sample, flipping the MSB for twos-complement output.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (load) result <= {sample_in[MSB] ^ twos_sel, sample_in[MSB-1:0]};
    end
endmodule

// File: rtl/sar_conv_sequencer.sv
// Module: top of the conversion sequencer; ties edge detect, phase control
// and result register together.
// Assumes: one clock domain; all inputs synchronous; rst_n synchronous.
module sar_conv_sequencer #(
    parameter int DATA_W   = 16,
    parameter int ACQ_CYC  = 4,
    parameter int CONV_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              pwr_dn,
    input  logic              cnv_n,
    input  logic              twos_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic [DATA_W-1:0] result
);
    logic cnv_fall;
    logic load;

    cnv_fall_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_n    (cnv_n),
        .cnv_fall (cnv_fall)
    );

    conv_phase_ctrl #(
        .ACQ_CYC  (ACQ_CYC),
        .CONV_CYC (CONV_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .pwr_dn   (pwr_dn),
        .cnv_n    (cnv_n),
        .cnv_fall (cnv_fall),
        .busy     (busy),
        .load     (load)
    );

    conv_result_reg #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .twos_sel  (twos_sel),
        .sample_in (sample_in),
        .result    (result)
    );
endmodule

// File: rtl/sar_conv_sequencer_chk.sv
// Module: assertion checker bound to the sequencer top.
// Assumes: inputs synchronous to clk; window lengths are tracked with
// counters rather than deep $past so large parameters stay cheap.
module sar_conv_sequencer_chk #(
    parameter int DATA_W   = 16,
    parameter int ACQ_CYC  = 4,
    parameter int CONV_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic              pwr_dn,
    input logic              twos_sel,
    input logic [DATA_W-1:0] sample_in,
    input logic              busy,
    input logic [DATA_W-1:0] result
);
    logic [31:0] hi_run;
    logic [31:0] lo_run;

    // Count consecutive busy-high and busy-low edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= busy ? hi_run + 1 : '0;
            lo_run <= busy ? '0 : ((lo_run == 32'hFFFF_FFFF) ? lo_run : lo_run + 1);
        end
    end

    p_busy_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> (hi_run == CONV_CYC));

    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    p_result_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |->
        (result == {$past(sample_in[DATA_W-1]) ^ $past(twos_sel), $past(sample_in[DATA_W-2:0])}));

    p_acq_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lo_run >= ACQ_CYC));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    p_pd_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_dn) |=> !busy);
endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(
    .DATA_W   (DATA_W),
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .pwr_dn    (pwr_dn),
    .twos_sel  (twos_sel),
    .sample_in (sample_in),
    .busy      (busy),
    .result    (result)
);

// File: tb/sar_conv_sequencer_test.sv
// Bench: directed phases plus seeded random stimulus, compared every cycle
// against a behavioural model built from the requirements.
module sar_conv_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int ACQ  = 4;
    localparam int CONV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort = 1'b0;
    logic          pwr_dn = 1'b0;
    logic          cnv_n = 1'b1;
    logic          twos_sel = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          busy;
    logic [DW-1:0] result;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R10";
    bit    compare_on = 1'b0;

    sar_conv_sequencer #(.DATA_W(DW), .ACQ_CYC(ACQ), .CONV_CYC(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .abort(abort), .pwr_dn(pwr_dn),
        .cnv_n(cnv_n), .twos_sel(twos_sel), .sample_in(sample_in),
        .busy(busy), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] exp_fmt(input logic [DW-1:0] s, input logic t);
        return t ? {~s[DW-1], s[DW-2:0]} : s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: 0 acquiring, 1 waiting for edge, 2 converting.
    int            m_phase = 0;
    int            m_left = ACQ;
    logic          m_prev = 1'b1;
    logic [DW-1:0] m_res = '0;
    always @(posedge clk) begin
        logic fall;
        if (!rst_n) begin
            m_phase = 0; m_left = ACQ; m_prev = 1'b1; m_res = '0;
        end else begin
            fall = m_prev && !cnv_n;
            if (abort) begin
                m_phase = 0; m_left = ACQ;
            end else if (m_phase == 0) begin
                if (m_left > 1) m_left--;
                else if (!pwr_dn) begin
                    if (!cnv_n) begin m_phase = 2; m_left = CONV; end
                    else m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (!pwr_dn && fall) begin m_phase = 2; m_left = CONV; end
            end else begin
                if (m_left == 1) begin
                    m_res = exp_fmt(sample_in, twos_sel);
                    m_phase = 0; m_left = ACQ;
                end else m_left--;
            end
            m_prev = cnv_n;
        end
    end

    // Per-cycle comparison plus a busy-width watcher (R1).
    int run_len = 0;
    bit run_abort = 1'b0;
    always @(negedge clk) begin
        if (compare_on) begin
            check({cur_req, " busy"}, {31'd0, busy}, {31'd0, m_phase == 2});
            check({cur_req, " result"}, {16'd0, result}, {16'd0, m_res});
            if (busy) begin
                run_len++;
                if (abort) run_abort = 1'b1;
            end else begin
                if (run_len != 0 && !run_abort) check("R1 width", run_len, CONV);
                run_len = 0;
                run_abort = 1'b0;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        // R10: reset state.
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 result", {16'd0, result}, 32'd0);
        rst_n = 1'b1;
        compare_on = 1'b1;

        // R5: request held low, immediate start each acquisition end.
        cur_req = "R5"; cnv_n = 1'b0; twos_sel = 1'b1; sample_in = 16'h1234;
        cyc(ACQ);
        check("R5 rise", {31'd0, busy}, 32'd1);
        cyc(40);
        wait_idle();
        cyc(1);
        check("R3 twos", {16'd0, result}, 32'h9234);

        // R3: straight binary.
        cur_req = "R3"; twos_sel = 1'b0; sample_in = 16'h8001;
        cyc(2); wait_idle(); cyc(1);
        check("R3 straight", {16'd0, result}, 32'h8001);

        // R6: request high at acquisition end, start on a later edge.
        cur_req = "R6"; cnv_n = 1'b1;
        wait_idle(); cyc(ACQ + 6);
        check("R6 armed idle", {31'd0, busy}, 32'd0);
        cnv_n = 1'b0; cyc(1); cnv_n = 1'b1;
        check("R6 edge start", {31'd0, busy}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            wait_idle(); cyc(ACQ + i); cnv_n = 1'b0; cyc(1); cnv_n = 1'b1;
        end

        // R7: pulses inside conversion and acquisition are ignored.
        cur_req = "R7"; wait_idle(); cyc(ACQ + 2);
        cnv_n = 1'b0; cyc(1); cnv_n = 1'b1;
        cyc(3); cnv_n = 1'b0; cyc(1); cnv_n = 1'b1;
        wait_idle(); cyc(1); cnv_n = 1'b0; cyc(1); cnv_n = 1'b1;
        cyc(ACQ + 3);
        check("R7 no start", {31'd0, busy}, 32'd0);

        // R9: power-down lets the running conversion finish, then blocks.
        cur_req = "R9"; cnv_n = 1'b0; cyc(1); cnv_n = 1'b1; cyc(2);
        pwr_dn = 1'b1; sample_in = 16'h5A5A;
        wait_idle(); cyc(1);
        check("R9 completes", {16'd0, result}, 32'h5A5A);
        for (int i = 0; i < 20; i++) begin cnv_n = i[0]; cyc(1); end
        check("R9 blocked", {31'd0, busy}, 32'd0);
        cnv_n = 1'b1; pwr_dn = 1'b0; cyc(2);

        // R8: abort mid-conversion, result kept.
        cur_req = "R8"; sample_in = 16'hFFFF;
        cnv_n = 1'b0; cyc(1); cnv_n = 1'b1; cyc(3);
        abort = 1'b1; cyc(1); abort = 1'b0;
        check("R8 busy low", {31'd0, busy}, 32'd0);
        check("R8 result kept", {16'd0, result}, 32'h5A5A);
        cyc(ACQ + 2);

        // R4 with R1, R2: seeded random traffic.
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 == 0) cnv_n = ~cnv_n;
            if ($urandom % 60 == 0) pwr_dn = ~pwr_dn;
            abort = ($urandom % 150 == 0);
            twos_sel = $urandom % 2;
            sample_in = DW'($urandom);
            cyc(1);
        end
        abort = 1'b0; pwr_dn = 1'b0;
        cyc(CONV + ACQ);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule